// File: doc/BRIEF.md
# Boot Vector Loader with Double-Fault Halt

This block runs the processor's start-up bus traffic and watches for the fault that stops the machine. When reset is released, it reads two 32-bit vectors from the bottom of the vector table. The long word at byte address 0x00000 becomes the supervisor stack pointer. The long word at 0x00004 becomes the program counter. Each long word is read as two 16-bit bus cycles, upper half first. After the second vector arrives, the block sets the 3-bit interrupt mask to its maximum and pulses a start signal to the core. It changes no other architectural state.

When the core begins handling a bus-error exception, the block enters a stacking phase. That phase lasts until the core reports that the next instruction has started. A bus error inside the stacking phase halts the machine. So does a bus error while either vector is being read. Once halted, the block can leave that state in only two ways: the asynchronous reset, or a watchdog timeout pulse. The watchdog timeout restarts the whole vector fetch.

Bus back-pressure works as follows. The block holds `bus_req` and `bus_addr` steady for as long as the responder needs. The cycle is over in the first clock in which `bus_ack` or `bus_err` is high. If both are high in the same cycle, the error takes priority.

Top module: `boot_fault_seq`

## Requirements
- R1: After reset is released, `bus_req` is high at once. The block reads byte addresses 0, 2, 4 and 6 in that order. Each new address appears in the cycle after the previous cycle ends.
- R2: The stack pointer output becomes {word at 0, word at 2} in the cycle after the response to address 2.
- R3: The program counter output becomes {word at 4, word at 6} in the cycle after the response to address 6.
- R4: In the cycle after the response to address 6, `int_mask` reads 7 (all ones) and `start` is high. `start` is high for exactly one cycle and at no other time.
- R5: While no response arrives, `bus_req` and `bus_addr` stay unchanged for any number of wait cycles. Data presented without `bus_ack` is never loaded.
- R6: A `bus_err` during the vector fetch sets `halt` and drops `bus_req` from the next cycle, with or without `bus_ack` in the same cycle. A vector that was fully loaded before the error keeps its value. A vector that was not fully loaded keeps its old value, and `start` does not pulse.
- R7: After the start pulse, `exc_begin` opens the stacking phase from the next cycle. A `bus_err` in any later cycle of that phase sets `halt` in the cycle that follows. A `bus_err` in the same cycle as `exc_begin` is not a double fault.
- R8: `insn_begin` closes the stacking phase, and `bus_err` outside the phase has no effect. If `insn_begin` and `bus_err` arrive in the same cycle during the phase, the result is a halt. If `exc_begin` and `insn_begin` arrive together, the phase opens.
- R9: `halt` stays high until reset or `wdog_tmo`. While halted, `bus_req` is low, and `bus_ack`, `bus_err`, `exc_begin` and `insn_begin` change nothing.
- R10: `wdog_tmo` while halted clears `halt` and restarts the fetch at address 0 in the next cycle. `wdog_tmo` at any other time is ignored.
- R11: While reset is asserted, `halt`, `start`, the stack pointer, the program counter and `int_mask` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous external reset, active low |
| wdog_tmo | input | 1 | Watchdog timeout pulse |
| bus_req | output | 1 | Vector read request, held until a response |
| bus_addr | output | 24 | Byte address of the 16-bit word being read |
| bus_rdata | input | 16 | Read data, valid together with bus_ack |
| bus_ack | input | 1 | Bus cycle completed normally |
| bus_err | input | 1 | Bus error response (also observed while the core stacks) |
| exc_begin | input | 1 | Core starts bus-error exception processing |
| insn_begin | input | 1 | Core starts executing an instruction |
| ssp | output | 32 | Supervisor stack pointer loaded from vector 0 |
| pc | output | 32 | Program counter loaded from vector 1 |
| int_mask | output | 3 | Interrupt mask level |
| start | output | 1 | One-cycle pulse when the vector fetch completes |
| halt | output | 1 | Double fault: machine halted |

## Verification
The fetch runs three ways: with zero wait states, with three wait states per word, and with junk on the data lines during the waits. Together these separate correct load timing from data captured outside an acknowledge.

Errors are injected at the first and second word of a vector, one of them together with an acknowledge. This shows which vectors survive, and that the error beats the acknowledge.

In the run state, the tests pair `bus_err` with `exc_begin`, with `insn_begin`, and with neither. These pairings tell an error that belongs to the phase from one that opens it or comes after it. Watchdog pulses are driven in the run state and in the halted state, and input activity is driven while halted, to confirm that only the halted watchdog restarts the machine.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_RUN   = 2'd1,
    ST_HALT  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/bfs_fetch_ctl.sv
module bfs_fetch_ctl #(
  parameter int ADDR_W   = 24,
  parameter int BUS_W    = 16,
  parameter int VEC_W    = 32,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              ld_ssp,
  output logic              ld_pc,
  output logic [VEC_W-1:0]  vec_value,
  output logic              fault
);
  localparam int WPV    = VEC_W / BUS_W;
  localparam int NWORDS = 2 * WPV;
  localparam int CW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int BYTES  = BUS_W / 8;
  localparam int ACC_W  = VEC_W - BUS_W;

  logic [CW-1:0]    widx;
  logic [ACC_W-1:0] acc, acc_nxt;
  logic             resp_ok;

  assign bus_req   = active;
  assign bus_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(widx) * ADDR_W'(BYTES);
  assign resp_ok   = active & bus_ack & ~bus_err;
  assign fault     = active & bus_err;
  assign ld_ssp    = resp_ok && (widx == CW'(WPV - 1));
  assign ld_pc     = resp_ok && (widx == CW'(NWORDS - 1));
  assign vec_value = {acc, bus_rdata};

  generate
    if (ACC_W > BUS_W) begin : g_wide
      assign acc_nxt = {acc[ACC_W-BUS_W-1:0], bus_rdata};
    end else begin : g_narrow
      assign acc_nxt = bus_rdata[ACC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx <= '0;
      acc  <= '0;
    end else if (!active) begin
      widx <= '0;
    end else if (resp_ok) begin
      widx <= widx + CW'(1);
      acc  <= acc_nxt;
    end
  end

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr)));

  assert_addr_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ((bus_addr - ADDR_W'(VEC_BASE)) < ADDR_W'(NWORDS * BYTES)));
endmodule

// File: rtl/bfs_stack_mon.sv
module bfs_stack_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic exc_begin,
  input  logic insn_begin,
  input  logic bus_err,
  output logic dbl_fault
);
  logic stk;

  assign dbl_fault = enable & stk & bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   stk <= 1'b0;
    else if (!enable || dbl_fault) stk <= 1'b0;
    else if (exc_begin)           stk <= 1'b1;
    else if (insn_begin)          stk <= 1'b0;
  end

  assert_phase_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(exc_begin) && bus_err) |-> dbl_fault);

  assert_phase_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $past(insn_begin && !exc_begin)) |-> !dbl_fault);
endmodule

// File: rtl/bfs_arch_regs.sv
module bfs_arch_regs #(
  parameter int VEC_W  = 32,
  parameter int MASK_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ssp,
  input  logic              ld_pc,
  input  logic [VEC_W-1:0]  value,
  output logic [VEC_W-1:0]  ssp,
  output logic [VEC_W-1:0]  pc,
  output logic [MASK_W-1:0] int_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssp      <= '0;
      pc       <= '0;
      int_mask <= '0;
    end else begin
      if (ld_ssp) ssp <= value;
      if (ld_pc) begin
        pc       <= value;
        int_mask <= '1;
      end
    end
  end
endmodule

// File: rtl/boot_fault_seq.sv
module boot_fault_seq #(
  parameter int ADDR_W   = 24,
  parameter int BUS_W    = 16,
  parameter int VEC_W    = 32,
  parameter int MASK_W   = 3,
  parameter int VEC_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdog_tmo,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              bus_ack,
  input  logic              bus_err,
  input  logic              exc_begin,
  input  logic              insn_begin,
  output logic [VEC_W-1:0]  ssp,
  output logic [VEC_W-1:0]  pc,
  output logic [MASK_W-1:0] int_mask,
  output logic              start,
  output logic              halt
);
  import bfs_pkg::*;

  seq_state_t         state, state_nxt;
  logic               ld_ssp, ld_pc, fetch_fault, dbl_fault;
  logic [VEC_W-1:0]   vec_value;

  bfs_fetch_ctl #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .active(state == ST_FETCH),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_addr(bus_addr),
    .ld_ssp(ld_ssp), .ld_pc(ld_pc), .vec_value(vec_value), .fault(fetch_fault)
  );

  bfs_stack_mon u_stk (
    .clk(clk), .rst_n(rst_n), .enable(state == ST_RUN),
    .exc_begin(exc_begin), .insn_begin(insn_begin), .bus_err(bus_err),
    .dbl_fault(dbl_fault)
  );

  bfs_arch_regs #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ld_ssp(ld_ssp), .ld_pc(ld_pc),
    .value(vec_value), .ssp(ssp), .pc(pc), .int_mask(int_mask)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_FETCH: if (fetch_fault) state_nxt = ST_HALT;
                else if (ld_pc) state_nxt = ST_RUN;
      ST_RUN:   if (dbl_fault) state_nxt = ST_HALT;
      ST_HALT:  if (wdog_tmo) state_nxt = ST_FETCH;
      default:  state_nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      start <= 1'b0;
    end else begin
      state <= state_nxt;
      start <= ld_pc;
    end
  end

  assign halt = (state == ST_HALT);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wdog_tmo) |=> (halt && !bus_req));

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_start_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (int_mask == {MASK_W{1'b1}}));

  assert_halt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> $past(bus_err));

  assert_wdog_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && wdog_tmo) |=> (bus_req && bus_addr == ADDR_W'(VEC_BASE)));
endmodule

// File: tb/tb_boot_fault_seq.sv
module tb_boot_fault_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdog_tmo = 1'b0;
  logic        bus_req;
  logic [23:0] bus_addr;
  logic [15:0] bus_rdata = 16'h0;
  logic        bus_ack = 1'b0, bus_err = 1'b0;
  logic        exc_begin = 1'b0, insn_begin = 1'b0;
  logic [31:0] ssp, pc;
  logic [2:0]  int_mask;
  logic        start, halt;

  int checks = 0, failures = 0, cyc = 0;
  logic [15:0] mem [4];

  boot_fault_seq dut (
    .clk(clk), .rst_n(rst_n), .wdog_tmo(wdog_tmo),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .bus_err(bus_err),
    .exc_begin(exc_begin), .insn_begin(insn_begin),
    .ssp(ssp), .pc(pc), .int_mask(int_mask), .start(start), .halt(halt)
  );

  always #5 clk = ~clk;

  // behavioural reference: 0 fetch, 1 run, 2 halted
  int          m_st, m_w;
  bit [15:0]   m_hi;
  bit [31:0]   m_ssp, m_pc;
  bit [2:0]    m_mask;
  bit          m_start, m_stk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_w = 0; m_hi = 0; m_ssp = 0; m_pc = 0; m_mask = 0;
      m_start = 0; m_stk = 0;
    end else begin
      m_start = 0;
      if (m_st == 0) begin
        if (bus_err) m_st = 2;
        else if (bus_ack) begin
          if (m_w == 1) m_ssp = {m_hi, bus_rdata};
          else if (m_w == 3) begin
            m_pc = {m_hi, bus_rdata}; m_mask = 3'd7; m_start = 1; m_st = 1;
          end
          m_hi = bus_rdata;
          m_w = m_w + 1;
        end
      end else if (m_st == 1) begin
        if (m_stk && bus_err) begin m_st = 2; m_stk = 0; end
        else if (exc_begin) m_stk = 1;
        else if (insn_begin) m_stk = 0;
      end else if (wdog_tmo) begin
        m_st = 0; m_w = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare against the reference every cycle, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(bus_req === (m_st == 0), "R1", "bus_req", 64'(bus_req), 64'(m_st == 0));
    if (m_st == 0) chk(bus_addr === 24'(m_w * 2), "R1", "bus_addr", 64'(bus_addr), 64'(m_w * 2));
    chk(ssp === m_ssp, "R2", "ssp", 64'(ssp), 64'(m_ssp));
    chk(pc === m_pc, "R3", "pc", 64'(pc), 64'(m_pc));
    chk(start === m_start, "R4", "start", 64'(start), 64'(m_start));
    chk(int_mask === m_mask, "R4", "int_mask", 64'(int_mask), 64'(m_mask));
    chk(halt === (m_st == 2), "R9", "halt", 64'(halt), 64'(m_st == 2));
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=%0d expected<20000", cyc);
      finish_run();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // serves the four vector words; err_at picks the word answered with an error
  task automatic serve(input int waits, input int err_at, input bit err_ack);
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < waits; j++) begin
        bus_rdata = 16'hDEAD ^ 16'(j);
        @(negedge clk);
      end
      bus_rdata = mem[k];
      if (k == err_at) begin
        bus_err = 1'b1; bus_ack = err_ack;
        @(negedge clk);
        bus_err = 1'b0; bus_ack = 1'b0;
        return;
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
    end
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0;
  endtask

  task automatic load_mem(input logic [63:0] v);
    mem[0] = v[63:48]; mem[1] = v[47:32]; mem[2] = v[31:16]; mem[3] = v[15:0];
  endtask

  initial begin
    step(3);
    // R11 reset values
    chk(halt === 1'b0 && start === 1'b0, "R11", "halt/start", {halt, start}, 0);
    chk(ssp === 0 && pc === 0 && int_mask === 0, "R11", "regs", 64'(ssp ^ pc), 0);
    rst_n = 1'b1;
    chk(bus_req === 1'b1 && bus_addr === 24'h0, "R1", "first request", 64'(bus_addr), 0);

    load_mem(64'h1234_5678_9ABC_DEF0);
    serve(0, -1, 0);
    chk(start === 1'b1 && int_mask === 3'd7, "R4", "start/mask", {start, int_mask}, 4'hF);
    chk(ssp === 32'h1234_5678, "R2", "ssp", 64'(ssp), 64'h1234_5678);
    chk(pc === 32'h9ABC_DEF0, "R3", "pc", 64'(pc), 64'h9ABC_DEF0);
    step(1);
    chk(start === 1'b0, "R4", "start single", 64'(start), 0);

    // R10 watchdog ignored while running
    pulse(wdog_tmo);
    chk(halt === 1'b0 && bus_req === 1'b0, "R10", "wdog in run", {halt, bus_req}, 0);

    // R8 error outside the phase; R7 error together with the opening pulse
    pulse(bus_err);
    chk(halt === 1'b0, "R8", "error without phase", 64'(halt), 0);
    exc_begin = 1'b1; bus_err = 1'b1; step(1); exc_begin = 1'b0; bus_err = 1'b0;
    chk(halt === 1'b0, "R7", "error with exc_begin", 64'(halt), 0);
    pulse(insn_begin);
    pulse(bus_err);
    chk(halt === 1'b0, "R8", "error after insn_begin", 64'(halt), 0);

    // R7 double fault during stacking
    pulse(exc_begin);
    step(2);
    pulse(bus_err);
    chk(halt === 1'b1 && bus_req === 1'b0, "R7", "stacking double fault", {halt, bus_req}, 2);

    // R9 activity while halted
    exc_begin = 1'b1; insn_begin = 1'b1; bus_ack = 1'b1; bus_err = 1'b1; bus_rdata = 16'hFFFF;
    step(3);
    exc_begin = 1'b0; insn_begin = 1'b0; bus_ack = 1'b0; bus_err = 1'b0;
    chk(halt === 1'b1 && ssp === 32'h1234_5678 && pc === 32'h9ABC_DEF0, "R9", "halt holds",
        64'(halt), 1);

    // R10 watchdog restart, R5 with wait states and junk data
    load_mem(64'hA5A5_0101_C3C3_0202);
    pulse(wdog_tmo);
    chk(halt === 1'b0 && bus_req === 1'b1 && bus_addr === 24'h0, "R10", "restart",
        64'(bus_addr), 0);
    serve(3, -1, 0);
    chk(ssp === 32'hA5A5_0101 && pc === 32'hC3C3_0202, "R5", "waited fetch",
        64'(ssp), 64'hA5A5_0101);

    // R8 insn_begin with error in same cycle still halts
    exc_begin = 1'b1; insn_begin = 1'b1; step(1); exc_begin = 1'b0; insn_begin = 1'b0;
    insn_begin = 1'b1; bus_err = 1'b1; step(1); insn_begin = 1'b0; bus_err = 1'b0;
    chk(halt === 1'b1, "R8", "error wins over insn_begin", 64'(halt), 1);

    // R6 error on the third word
    load_mem(64'h1111_2222_3333_4444);
    pulse(wdog_tmo);
    serve(1, 2, 0);
    chk(halt === 1'b1 && ssp === 32'h1111_2222 && pc === 32'hC3C3_0202, "R6",
        "error on pc word", 64'(pc), 64'hC3C3_0202);

    // R6 error with ack on the second word
    load_mem(64'h5555_6666_7777_8888);
    pulse(wdog_tmo);
    serve(0, 1, 1);
    chk(halt === 1'b1 && ssp === 32'h1111_2222, "R6", "error beats ack", 64'(ssp),
        64'h1111_2222);
    step(2);

    // R11 reset again mid-run, then a clean fetch
    #1 rst_n = 1'b0;
    step(2);
    chk(halt === 1'b0 && ssp === 0 && pc === 0 && int_mask === 0, "R11", "second reset",
        64'(ssp), 0);
    rst_n = 1'b1;
    serve(2, -1, 0);
    chk(start === 1'b1 && ssp === 32'h5555_6666 && pc === 32'h7777_8888, "R4", "final fetch",
        64'(pc), 64'h7777_8888);
    step(2);
    finish_run();
  end
endmodule